// File: doc/BRIEF.md
# Instruction Criticality Flag Generator

This block marks issue-queue entries as critical so that the surrounding core can steer power or scheduling decisions toward the instructions that hold up the window. It needs no learned tables. Every cycle it looks at the current issue-queue contents: valid bits, age stamps, and the two source-producer entry indices of each entry with their ready bits. It also looks at the age of the reorder buffer's head. From these it computes one critical bit per issue-queue entry.

A 2-bit run-time selector picks the rule used to mark entries. Mode 0 marks the N oldest entries. Mode 1 marks the in-flight producers of the oldest entry. Mode 2 marks the entry that is also the oldest instruction in the reorder buffer. Mode 3 marks entries whose completion would release at least N waiting dependents. N is a 3-bit run-time input. The flags are computed combinationally and then pass through one register before they reach the output.

Age stamps are unique and unsigned, and a smaller stamp means an older instruction.

Top module: `crit_flag_gen`

## Requirements
- R1: While `rst` is high, `crit_flags` is cleared to all zeros on each clock edge.
- R2: The `crit_flags` value seen after a rising edge is a function only of the inputs sampled at that edge, so the flags have exactly one cycle of latency.
- R3: An entry whose valid bit is 0 is never flagged, in any mode.
- R4: In mode 0 (`metric_sel`=0), a valid entry is flagged exactly when fewer than `n_thresh` valid entries have a strictly smaller age. When `n_thresh`=0, no entry is flagged.
- R5: In mode 1, the oldest valid entry is the one with the minimum age, and a tie goes to the lowest index. For each source of that entry whose ready bit is 0, the valid entry named by that source index is flagged. The oldest entry is not flagged for being oldest, and at most two entries are flagged.
- R6: In mode 2, when `rob_nonempty` is 1, the valid entries whose age equals `rob_head_age` are flagged. When `rob_nonempty` is 0, no entry is flagged.
- R7: In mode 3, a valid entry i is flagged when the number of other valid entries j (j≠i) with at least one non-ready source naming i is at least `n_thresh`. An entry counts once even if both of its sources name i, and ready sources are ignored. When `n_thresh`=0, every valid entry is flagged.
- R8: When no issue-queue entry is valid, the flags are all zero in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| metric_sel | input | 2 | Rule select: 0 oldest-N, 1 producers of oldest, 2 ROB head, 3 dependents released |
| n_thresh | input | 3 | Run-time N for modes 0 and 3 |
| iq_valid | input | 16 | Per-entry valid bits |
| iq_age | input | 96 | Age stamps, 6 bits per entry, entry i at bits [6i+5:6i] |
| iq_src0_idx | input | 64 | First source producer index, 4 bits per entry |
| iq_src0_rdy | input | 16 | First source ready bits |
| iq_src1_idx | input | 64 | Second source producer index, 4 bits per entry |
| iq_src1_rdy | input | 16 | Second source ready bits |
| rob_nonempty | input | 1 | Reorder buffer holds at least one instruction |
| rob_head_age | input | 6 | Age stamp of the reorder buffer's oldest instruction |
| crit_flags | output | 16 | Registered per-entry critical flags |

## Verification
The bench sweeps N across its boundaries. In mode 0, N=0 must flag nothing; an off-by-one comparison would flag one entry too many. In mode 3, N=0 must flag every valid entry. A chain of producers with a self-reference tests the rule that a self-reference does not count as a dependent, and a design that counted it would flag entry 4 at the highest threshold. Other cases make the oldest entry invalid, point a producer index at an invalid entry, and mark one of the oldest entry's sources ready. A design that ignored validity or ready bits would flag extra entries in these cases. The bench also issues back-to-back patterns with different expected results, which exposes any latency other than one cycle.

// File: rtl/crit_pkg.sv
package crit_pkg;
  typedef enum logic [1:0] {
    CM_OLDEST_N    = 2'd0,
    CM_OLDEST_PROD = 2'd1,
    CM_ROB_HEAD    = 2'd2,
    CM_FANOUT      = 2'd3
  } crit_mode_e;
endpackage

// File: rtl/crit_age_rank.sv
// Age ranking: per-entry count of older valid entries, oldest-N mask,
// and the index of the single oldest valid entry.
module crit_age_rank #(
  parameter int DEPTH = 16,
  parameter int AGE_W = 6,
  parameter int N_W   = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]       valid,
  input  logic [DEPTH*AGE_W-1:0] age_flat,
  input  logic [N_W-1:0]         n_val,
  output logic [DEPTH-1:0]       oldest_n_mask,
  output logic [IDX_W-1:0]       oldest_idx,
  output logic                   any_valid
);
  logic [AGE_W-1:0] age [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
    assign age[g] = age_flat[g*AGE_W +: AGE_W];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_rank
    logic [CNT_W-1:0] older_cnt;
    always_comb begin
      older_cnt = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (valid[j] && (age[j] < age[g])) older_cnt = older_cnt + 1'b1;
      end
      oldest_n_mask[g] = valid[g] && (older_cnt < CNT_W'(n_val));
    end
  end

  logic [AGE_W-1:0] best_age;
  always_comb begin
    any_valid  = 1'b0;
    oldest_idx = '0;
    best_age   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid[i] && (!any_valid || (age[i] < best_age))) begin
        any_valid  = 1'b1;
        oldest_idx = IDX_W'(i);
        best_age   = age[i];
      end
    end
  end
endmodule

// File: rtl/crit_fanout.sv
// Counts, for each entry, the other valid entries waiting on it.
module crit_fanout #(
  parameter int DEPTH = 16,
  parameter int N_W   = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]       valid,
  input  logic [DEPTH*IDX_W-1:0] s0_flat,
  input  logic [DEPTH-1:0]       r0,
  input  logic [DEPTH*IDX_W-1:0] s1_flat,
  input  logic [DEPTH-1:0]       r1,
  input  logic [N_W-1:0]         n_val,
  output logic [DEPTH-1:0]       fan_mask
);
  logic [IDX_W-1:0] s0 [DEPTH];
  logic [IDX_W-1:0] s1 [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
    assign s0[g] = s0_flat[g*IDX_W +: IDX_W];
    assign s1[g] = s1_flat[g*IDX_W +: IDX_W];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cnt
    logic [CNT_W-1:0] dep_cnt;
    always_comb begin
      dep_cnt = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (valid[j] && (j != g) &&
            (((s0[j] == IDX_W'(g)) && !r0[j]) || ((s1[j] == IDX_W'(g)) && !r1[j])))
          dep_cnt = dep_cnt + 1'b1;
      end
      fan_mask[g] = valid[g] && (dep_cnt >= CNT_W'(n_val));
    end
  end
endmodule

// File: rtl/crit_flag_gen.sv
module crit_flag_gen
  import crit_pkg::*;
#(
  parameter int IQ_DEPTH = 16,
  parameter int AGE_W    = 6,
  parameter int N_W      = 3,
  localparam int IDX_W   = $clog2(IQ_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                metric_sel,
  input  logic [N_W-1:0]            n_thresh,
  input  logic [IQ_DEPTH-1:0]       iq_valid,
  input  logic [IQ_DEPTH*AGE_W-1:0] iq_age,
  input  logic [IQ_DEPTH*IDX_W-1:0] iq_src0_idx,
  input  logic [IQ_DEPTH-1:0]       iq_src0_rdy,
  input  logic [IQ_DEPTH*IDX_W-1:0] iq_src1_idx,
  input  logic [IQ_DEPTH-1:0]       iq_src1_rdy,
  input  logic                      rob_nonempty,
  input  logic [AGE_W-1:0]          rob_head_age,
  output logic [IQ_DEPTH-1:0]       crit_flags
);
  logic [IQ_DEPTH-1:0] oldn_mask, fan_mask, prod_mask, rob_mask, next_flags;
  logic [IDX_W-1:0]    old_idx;
  logic                any_v;

  crit_age_rank #(.DEPTH(IQ_DEPTH), .AGE_W(AGE_W), .N_W(N_W)) u_rank (
    .valid(iq_valid), .age_flat(iq_age), .n_val(n_thresh),
    .oldest_n_mask(oldn_mask), .oldest_idx(old_idx), .any_valid(any_v)
  );

  crit_fanout #(.DEPTH(IQ_DEPTH), .N_W(N_W)) u_fan (
    .valid(iq_valid), .s0_flat(iq_src0_idx), .r0(iq_src0_rdy),
    .s1_flat(iq_src1_idx), .r1(iq_src1_rdy), .n_val(n_thresh),
    .fan_mask(fan_mask)
  );

  // Producers of the oldest entry, read through its source fields.
  logic [IDX_W-1:0] old_s0, old_s1;
  logic             old_w0, old_w1;
  assign old_s0 = iq_src0_idx[old_idx*IDX_W +: IDX_W];
  assign old_s1 = iq_src1_idx[old_idx*IDX_W +: IDX_W];
  assign old_w0 = any_v && !iq_src0_rdy[old_idx];
  assign old_w1 = any_v && !iq_src1_rdy[old_idx];

  for (genvar g = 0; g < IQ_DEPTH; g++) begin : g_entry
    assign prod_mask[g] = iq_valid[g] &&
                          ((old_w0 && (old_s0 == IDX_W'(g))) ||
                           (old_w1 && (old_s1 == IDX_W'(g))));
    assign rob_mask[g]  = iq_valid[g] && rob_nonempty &&
                          (iq_age[g*AGE_W +: AGE_W] == rob_head_age);
  end

  always_comb begin
    unique case (crit_mode_e'(metric_sel))
      CM_OLDEST_N:    next_flags = oldn_mask;
      CM_OLDEST_PROD: next_flags = prod_mask;
      CM_ROB_HEAD:    next_flags = rob_mask;
      CM_FANOUT:      next_flags = fan_mask;
      default:        next_flags = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) crit_flags <= '0;
    else     crit_flags <= next_flags;
  end
endmodule

// File: rtl/crit_flag_chk.sv
module crit_flag_chk #(
  parameter int DEPTH = 16,
  parameter int N_W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       metric_sel,
  input logic [N_W-1:0]   n_thresh,
  input logic [DEPTH-1:0] iq_valid,
  input logic             rob_nonempty,
  input logic [DEPTH-1:0] crit_flags
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    (started && $past(rst)) |-> (crit_flags == '0));

  // R3
  no_invalid_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (crit_flags & ~$past(iq_valid)) == '0);

  // R8
  empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (iq_valid == '0) |=> (crit_flags == '0));

  // R6
  rob_empty_chk: assert property (@(posedge clk) disable iff (rst)
    ((metric_sel == 2'd2) && !rob_nonempty) |=> (crit_flags == '0));

  // R5
  prod_count_chk: assert property (@(posedge clk) disable iff (rst)
    (metric_sel == 2'd1) |=> ($countones(crit_flags) <= 2));

  // R7
  fanout_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((metric_sel == 2'd3) && (n_thresh == '0)) |=> (crit_flags == $past(iq_valid)));
endmodule

bind crit_flag_gen crit_flag_chk #(.DEPTH(IQ_DEPTH), .N_W(N_W)) u_chk (
  .clk(clk), .rst(rst), .metric_sel(metric_sel), .n_thresh(n_thresh),
  .iq_valid(iq_valid), .rob_nonempty(rob_nonempty), .crit_flags(crit_flags)
);

// File: tb/crit_flag_gen_bench.sv
module crit_flag_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D = 16;
  localparam int AW = 6;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]      metric_sel = '0;
  logic [2:0]      n_thresh = '0;
  logic [D-1:0]    iq_valid = '0;
  logic [D*AW-1:0] iq_age = '0;
  logic [D*IW-1:0] iq_src0_idx = '0;
  logic [D-1:0]    iq_src0_rdy = '1;
  logic [D*IW-1:0] iq_src1_idx = '0;
  logic [D-1:0]    iq_src1_rdy = '1;
  logic            rob_nonempty = 1'b0;
  logic [AW-1:0]   rob_head_age = '0;
  logic [D-1:0]    crit_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  crit_flag_gen u_crit_flag_gen (
    .clk(clk), .rst(rst), .metric_sel(metric_sel), .n_thresh(n_thresh),
    .iq_valid(iq_valid), .iq_age(iq_age),
    .iq_src0_idx(iq_src0_idx), .iq_src0_rdy(iq_src0_rdy),
    .iq_src1_idx(iq_src1_idx), .iq_src1_rdy(iq_src1_rdy),
    .rob_nonempty(rob_nonempty), .rob_head_age(rob_head_age),
    .crit_flags(crit_flags)
  );

  // Bench view of the queue.
  logic [D-1:0]  bv;
  logic [AW-1:0] bage [D];
  logic [IW-1:0] bs0 [D];
  logic [IW-1:0] bs1 [D];
  logic [D-1:0]  br0, br1;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [D-1:0] exp_q [$];
  string        tag_q [$];

  function automatic logic [D-1:0] model(input int mode, input int n,
                                         input bit rne, input int rage);
    logic [D-1:0] r = '0;
    int o = -1;
    for (int i = 0; i < D; i++) begin
      if (!bv[i]) continue;
      if (mode == 0) begin
        int c = 0;
        for (int j = 0; j < D; j++) if (bv[j] && bage[j] < bage[i]) c++;
        r[i] = (c < n);
      end else if (mode == 2) begin
        r[i] = rne && (int'(bage[i]) == rage);
      end else if (mode == 3) begin
        int c = 0;
        for (int j = 0; j < D; j++)
          if (bv[j] && j != i && ((int'(bs0[j]) == i && !br0[j]) ||
                                  (int'(bs1[j]) == i && !br1[j]))) c++;
        r[i] = (c >= n);
      end
    end
    if (mode == 1) begin
      for (int i = 0; i < D; i++)
        if (bv[i] && (o < 0 || bage[i] < bage[o])) o = i;
      if (o >= 0) begin
        if (!br0[o] && bv[bs0[o]]) r[bs0[o]] = 1'b1;
        if (!br1[o] && bv[bs1[o]]) r[bs1[o]] = 1'b1;
      end
    end
    return r;
  endfunction

  // Driver: apply one pattern after an edge and queue its expectation.
  task automatic drive(input int mode, input int n, input bit rne,
                       input int rage, input string tag);
    @(posedge clk);
    #1;
    metric_sel   = 2'(mode);
    n_thresh     = 3'(n);
    rob_nonempty = rne;
    rob_head_age = AW'(rage);
    iq_valid     = bv;
    iq_src0_rdy  = br0;
    iq_src1_rdy  = br1;
    for (int i = 0; i < D; i++) begin
      iq_age[i*AW +: AW]      = bage[i];
      iq_src0_idx[i*IW +: IW] = bs0[i];
      iq_src1_idx[i*IW +: IW] = bs1[i];
    end
    exp_q.push_back(model(mode, n, rne, rage));
    tag_q.push_back(tag);
  endtask

  // Monitor: compare items queued before this edge.
  always @(posedge clk) begin
    int pend;
    pend = exp_q.size();
    #3;
    for (int k = 0; k < pend; k++) begin
      logic [D-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (crit_flags !== e) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", t, crit_flags, e);
      end
    end
  end

  task automatic default_q();
    bv = '1; br0 = '1; br1 = '1;
    for (int i = 0; i < D; i++) begin
      bage[i] = AW'((i * 5) % 16 + 2);
      bs0[i] = '0;
      bs1[i] = '0;
    end
  endtask

  initial begin
    default_q();
    repeat (3) @(posedge clk);
    #3;
    tests++;
    if (crit_flags !== '0) begin
      fails++;
      $display("FAIL R1: actual %h expected %h", crit_flags, 16'h0);
    end
    @(posedge clk); #1 rst = 1'b0;

    // R8: empty queue in every mode
    bv = '0;
    for (int m = 0; m < 4; m++) drive(m, 0, 1'b1, 2, "R8");

    // R4: oldest-N sweep, including N=0 and N=7
    default_q();
    drive(0, 0, 1'b0, 0, "R4");
    drive(0, 1, 1'b0, 0, "R4");
    drive(0, 3, 1'b0, 0, "R2");
    drive(0, 7, 1'b0, 0, "R4");
    // R3: half the queue invalid
    bv = 16'h5A5A;
    drive(0, 7, 1'b0, 0, "R3");
    drive(0, 2, 1'b0, 0, "R3");

    // R5: producers of the oldest entry (entry 0, age 2)
    default_q();
    bs0[0] = 4'd5; br0[0] = 1'b0;
    bs1[0] = 4'd9; br1[0] = 1'b0;
    drive(1, 0, 1'b0, 0, "R5");
    br1[0] = 1'b1;
    drive(1, 0, 1'b0, 0, "R5");
    bv[5] = 1'b0;
    drive(1, 0, 1'b0, 0, "R3");
    bv = '1; bv[0] = 1'b0;
    bs0[13] = 4'd7; br0[13] = 1'b0;
    drive(1, 0, 1'b0, 0, "R5");

    // R6: reorder-buffer head match
    default_q();
    drive(2, 0, 1'b1, 12, "R6");
    drive(2, 0, 1'b0, 12, "R6");
    bv[2] = 1'b0;
    drive(2, 0, 1'b1, 12, "R6");
    drive(2, 0, 1'b1, 63, "R6");

    // R7: dependents released
    default_q();
    bs0[1] = 4'd4; br0[1] = 1'b0;
    bs0[2] = 4'd4; br0[2] = 1'b0;
    bs1[3] = 4'd4; br1[3] = 1'b0;
    bs0[6] = 4'd7; br0[6] = 1'b0;
    bs0[8] = 4'd7; br0[8] = 1'b1;
    bs1[4] = 4'd4; br1[4] = 1'b0;
    for (int n = 0; n < 5; n++) drive(3, n, 1'b0, 0, "R7");
    bv[2] = 1'b0;
    drive(3, 3, 1'b0, 0, "R7");
    drive(3, 2, 1'b0, 0, "R2");

    repeat (3) @(posedge clk);
    #4;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule